// File: doc/BRIEF.md
# Time-Slot Channel Assigner

The assigner connects a set of byte FIFOs to the 32 byte slots of a framed line, one byte per slot in every 125 µs frame. The line side and a second, PCM-style highway each offer a bus carrying the 32 received slot bytes and take a bus of 32 transmit slot bytes. A transmit table and a receive table each hold one routing entry per FIFO. An entry holds an enable, a target slot number, and a bypass flag. With bypass clear, the entry moves one byte between the FIFO and the line slot. With bypass set, the entry still occupies its FIFO number, but the byte crosses directly between the PCM slot and the line slot of the same number, and the FIFO is left untouched.

Software loads entries through a one-cycle write port into a pending copy of the tables. A single `frame_tick` copies the pending tables into the active tables, and the transfer for that frame runs in the following cycle using the active tables. Any FIFO may serve any slot from 1 to 31. Slot 0 is reserved. Any slot that no usable entry claims idles at 0xFF.

Top module: `tsa_channel_assigner`

## Requirements
- R1: While reset is held and after it is released, every transmit slot byte on both buses reads 0xFF and no pop, push or underrun strobe is asserted.
- R2: A write (`cfg_we`) with `cfg_dir` = 0 loads the transmit entry and with `cfg_dir` = 1 loads the receive entry of FIFO `cfg_fifo` into the pending tables. `frame_tick` copies the pending tables into the active ones. A write issued in the same cycle as `frame_tick` first governs the frame of the next tick.
- R3: A write whose `cfg_fifo` is not below `NUM_FIFO` changes no entry.
- R4: Pop, push and underrun strobes occur only in the cycle after `frame_tick`. The transmit slot buses change only on the clock edge that ends that cycle and hold their value until the next transfer. Slot k occupies bits [8k+7:8k] of each slot bus, and FIFO i occupies bits [8i+7:8i] of each per-FIFO data bus.
- R5: A usable transmit entry without bypass whose FIFO shows `tx_fifo_valid` pops that FIFO once and places its byte on the line transmit slot of the entry.
- R6: If that FIFO is empty, the line transmit slot carries 0xFF, `tx_underrun` pulses for that FIFO and nothing is popped.
- R7: A usable receive entry without bypass pushes the line receive byte of its slot into its FIFO on `rx_fifo_data`.
- R8: A usable transmit entry with bypass copies the PCM receive byte of its slot to the line transmit slot of the same number, with no pop and no underrun.
- R9: A usable receive entry with bypass copies the line receive byte of its slot to the PCM transmit slot of the same number, with no push.
- R10: An entry is usable only when it is enabled and targets a slot other than 0. Slot 0 and every slot claimed by no usable entry transmit 0xFF on both buses, and their received bytes go nowhere.
- R11: When several usable entries of one table target the same slot, the lowest FIFO number serves the slot. The others cause no strobe and no slot data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | Frame boundary strobe |
| cfg_we | input | 1 | Entry write strobe |
| cfg_dir | input | 1 | Table select, 0 transmit, 1 receive |
| cfg_fifo | input | FIFO_AW (5) | FIFO number written |
| cfg_slot | input | 5 | Target slot of the entry |
| cfg_bypass | input | 1 | Direct PCM/line connection |
| cfg_en | input | 1 | Entry enable |
| tx_fifo_valid | input | NUM_FIFO (4) | Transmit FIFO holds a byte |
| tx_fifo_data | input | 8*NUM_FIFO (32) | Head byte of each transmit FIFO |
| tx_fifo_pop | output | NUM_FIFO (4) | Take head byte |
| tx_underrun | output | NUM_FIFO (4) | Transmit FIFO was empty at its slot |
| rx_fifo_push | output | NUM_FIFO (4) | Store byte in receive FIFO |
| rx_fifo_data | output | 8*NUM_FIFO (32) | Byte for each receive FIFO |
| line_rx_slots | input | 256 | Line receive slot bytes |
| pcm_rx_slots | input | 256 | PCM receive slot bytes |
| line_tx_slots | output | 256 | Line transmit slot bytes |
| pcm_tx_slots | output | 256 | PCM transmit slot bytes |

## Verification
A corrupted active entry shows on the next transfer. The wrong slot carries the FIFO byte, a strobe lands on the wrong FIFO bit, or a claimed slot idles at 0xFF. All of this becomes visible one cycle after the tick for the strobes and two cycles after it for the slot buses. A pending/active mix-up appears only when a write and a tick coincide, so that case is driven on purpose. A broken priority chain appears only when two entries share a slot, and is probed in both tables with mixed bypass settings.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_SLOTS = 32;
    localparam int SLOT_AW   = $clog2(NUM_SLOTS);
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    typedef enum logic {
        TBL_TX = 1'b0,
        TBL_RX = 1'b1
    } tbl_e;

    typedef struct packed {
        logic               en;
        logic               bypass;
        logic [SLOT_AW-1:0] slot;
    } route_t;

    localparam route_t ROUTE_OFF = '{en: 1'b0, bypass: 1'b0, slot: '0};

    // slot 0 is reserved, so an entry pointing there is never served
    function automatic logic route_usable(route_t r);
        return r.en && (r.slot != '0);
    endfunction

endpackage

// File: rtl/tsa_cfg_bank.sv
module tsa_cfg_bank
    import tsa_pkg::*;
#(
    parameter int NUM_FIFO = 4,
    parameter int FIFO_AW  = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         commit,
    input  logic                         we,
    input  logic [FIFO_AW-1:0]           idx,
    input  route_t                       wdata,
    output route_t [NUM_FIFO-1:0]        active
);

    route_t [NUM_FIFO-1:0] pending;

    for (genvar i = 0; i < NUM_FIFO; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                pending[i] <= ROUTE_OFF;
                active[i]  <= ROUTE_OFF;
            end else begin
                if (commit) begin
                    active[i] <= pending[i];
                end
                if (we && (idx == FIFO_AW'(i))) begin
                    pending[i] <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/tsa_route_select.sv
module tsa_route_select
    import tsa_pkg::*;
#(
    parameter int NUM_FIFO = 4
) (
    input  route_t [NUM_FIFO-1:0] routes,
    output logic   [NUM_FIFO-1:0] serves
);

    // an entry serves its slot unless a lower-numbered usable entry claims it
    always_comb begin
        for (int i = 0; i < NUM_FIFO; i++) begin
            serves[i] = route_usable(routes[i]);
            for (int j = 0; j < NUM_FIFO; j++) begin
                if (j < i && route_usable(routes[j]) &&
                    routes[j].slot == routes[i].slot) begin
                    serves[i] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/tsa_channel_assigner.sv
module tsa_channel_assigner
    import tsa_pkg::*;
#(
    parameter int NUM_FIFO = 4,
    parameter int FIFO_AW  = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_tick,
    input  logic                          cfg_we,
    input  logic                          cfg_dir,
    input  logic [FIFO_AW-1:0]            cfg_fifo,
    input  logic [4:0]                    cfg_slot,
    input  logic                          cfg_bypass,
    input  logic                          cfg_en,
    input  logic [NUM_FIFO-1:0]           tx_fifo_valid,
    input  logic [NUM_FIFO*8-1:0]         tx_fifo_data,
    output logic [NUM_FIFO-1:0]           tx_fifo_pop,
    output logic [NUM_FIFO-1:0]           tx_underrun,
    output logic [NUM_FIFO-1:0]           rx_fifo_push,
    output logic [NUM_FIFO*8-1:0]         rx_fifo_data,
    input  logic [255:0]                  line_rx_slots,
    input  logic [255:0]                  pcm_rx_slots,
    output logic [255:0]                  line_tx_slots,
    output logic [255:0]                  pcm_tx_slots
);

    localparam int BUS_W = NUM_SLOTS * BYTE_W;

    logic   xfer_q;
    route_t wr_route;
    route_t [NUM_FIFO-1:0] tx_tab, rx_tab;
    logic   [NUM_FIFO-1:0] tx_serves, rx_serves;

    logic [BYTE_W-1:0] line_rx_b [NUM_SLOTS];
    logic [BYTE_W-1:0] pcm_rx_b  [NUM_SLOTS];
    logic [BYTE_W-1:0] line_nxt  [NUM_SLOTS];
    logic [BYTE_W-1:0] pcm_nxt   [NUM_SLOTS];
    logic [BYTE_W-1:0] line_q    [NUM_SLOTS];
    logic [BYTE_W-1:0] pcm_q     [NUM_SLOTS];

    assign wr_route = '{en: cfg_en, bypass: cfg_bypass, slot: cfg_slot};

    always_ff @(posedge clk) begin
        if (rst) xfer_q <= 1'b0;
        else     xfer_q <= frame_tick;
    end

    tsa_cfg_bank #(.NUM_FIFO(NUM_FIFO), .FIFO_AW(FIFO_AW)) tx_bank_i (
        .clk(clk), .rst(rst), .commit(frame_tick),
        .we(cfg_we && (tbl_e'(cfg_dir) == TBL_TX)),
        .idx(cfg_fifo), .wdata(wr_route), .active(tx_tab)
    );

    tsa_cfg_bank #(.NUM_FIFO(NUM_FIFO), .FIFO_AW(FIFO_AW)) rx_bank_i (
        .clk(clk), .rst(rst), .commit(frame_tick),
        .we(cfg_we && (tbl_e'(cfg_dir) == TBL_RX)),
        .idx(cfg_fifo), .wdata(wr_route), .active(rx_tab)
    );

    tsa_route_select #(.NUM_FIFO(NUM_FIFO)) tx_sel_i (.routes(tx_tab), .serves(tx_serves));
    tsa_route_select #(.NUM_FIFO(NUM_FIFO)) rx_sel_i (.routes(rx_tab), .serves(rx_serves));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign line_rx_b[s] = line_rx_slots[s*BYTE_W +: BYTE_W];
        assign pcm_rx_b[s]  = pcm_rx_slots[s*BYTE_W +: BYTE_W];
        assign line_tx_slots[s*BYTE_W +: BYTE_W] = line_q[s];
        assign pcm_tx_slots[s*BYTE_W +: BYTE_W]  = pcm_q[s];

        always_ff @(posedge clk) begin
            if (rst) begin
                line_q[s] <= IDLE_BYTE;
                pcm_q[s]  <= IDLE_BYTE;
            end else if (xfer_q) begin
                line_q[s] <= line_nxt[s];
                pcm_q[s]  <= pcm_nxt[s];
            end
        end
    end

    always_comb begin
        tx_fifo_pop  = '0;
        tx_underrun  = '0;
        rx_fifo_push = '0;
        rx_fifo_data = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            line_nxt[s] = IDLE_BYTE;
            pcm_nxt[s]  = IDLE_BYTE;
        end
        for (int i = 0; i < NUM_FIFO; i++) begin
            if (tx_serves[i]) begin
                if (tx_tab[i].bypass) begin
                    line_nxt[tx_tab[i].slot] = pcm_rx_b[tx_tab[i].slot];
                end else if (tx_fifo_valid[i]) begin
                    line_nxt[tx_tab[i].slot] = tx_fifo_data[i*BYTE_W +: BYTE_W];
                    tx_fifo_pop[i] = xfer_q;
                end else begin
                    tx_underrun[i] = xfer_q;
                end
            end
            if (rx_serves[i]) begin
                if (rx_tab[i].bypass) begin
                    pcm_nxt[rx_tab[i].slot] = line_rx_b[rx_tab[i].slot];
                end else begin
                    rx_fifo_push[i] = xfer_q;
                    rx_fifo_data[i*BYTE_W +: BYTE_W] = line_rx_b[rx_tab[i].slot];
                end
            end
        end
    end

    logic unused_ok;
    assign unused_ok = &{1'b0, BUS_W[0]};

endmodule

// File: rtl/tsa_channel_assigner_chk.sv
module tsa_channel_assigner_chk #(
    parameter int NUM_FIFO = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                frame_tick,
    input logic [NUM_FIFO-1:0] tx_fifo_valid,
    input logic [NUM_FIFO-1:0] tx_fifo_pop,
    input logic [NUM_FIFO-1:0] tx_underrun,
    input logic [NUM_FIFO-1:0] rx_fifo_push,
    input logic [255:0]        line_tx_slots,
    input logic [255:0]        pcm_tx_slots
);

    p_strobe_after_tick_r4: assert property (@(posedge clk) disable iff (rst)
        (|{tx_fifo_pop, tx_underrun, rx_fifo_push}) |-> $past(frame_tick));

    p_slots_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !($stable(line_tx_slots) && $stable(pcm_tx_slots)) |-> $past(frame_tick, 2));

    p_pop_needs_data_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_fifo_pop & ~tx_fifo_valid) == '0);

    p_underrun_only_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_underrun & (tx_fifo_valid | tx_fifo_pop)) == '0);

    p_slot0_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (line_tx_slots[7:0] == 8'hFF) && (pcm_tx_slots[7:0] == 8'hFF));

endmodule

bind tsa_channel_assigner tsa_channel_assigner_chk #(.NUM_FIFO(NUM_FIFO)) chk_i (
    .clk(clk), .rst(rst), .frame_tick(frame_tick),
    .tx_fifo_valid(tx_fifo_valid), .tx_fifo_pop(tx_fifo_pop),
    .tx_underrun(tx_underrun), .rx_fifo_push(rx_fifo_push),
    .line_tx_slots(line_tx_slots), .pcm_tx_slots(pcm_tx_slots)
);

// File: tb/tsa_channel_assigner_tb_top.sv
module tsa_channel_assigner_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NF = 4;
    localparam int NS = 32;

    typedef struct {
        bit en;
        bit byp;
        int slot;
    } ent_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_tick = 1'b0;
    logic cfg_we = 1'b0, cfg_dir = 1'b0, cfg_bypass = 1'b0, cfg_en = 1'b0;
    logic [4:0] cfg_fifo = '0;
    logic [4:0] cfg_slot = '0;
    logic [NF-1:0] tx_fifo_valid = '1;
    logic [NF*8-1:0] tx_fifo_data = '0;
    logic [NF-1:0] tx_fifo_pop, tx_underrun, rx_fifo_push;
    logic [NF*8-1:0] rx_fifo_data;
    logic [255:0] line_rx_slots = '0, pcm_rx_slots = '0;
    logic [255:0] line_tx_slots, pcm_tx_slots;

    int n_tests = 0;
    int n_fail = 0;
    int seed = 0;

    ent_t ptx[NF], prx[NF], atx[NF], arx[NF];

    always #(CLK_PERIOD/2) clk = ~clk;

    tsa_channel_assigner #(.NUM_FIFO(NF), .FIFO_AW(5)) dut_i (
        .clk(clk), .rst(rst), .frame_tick(frame_tick),
        .cfg_we(cfg_we), .cfg_dir(cfg_dir), .cfg_fifo(cfg_fifo),
        .cfg_slot(cfg_slot), .cfg_bypass(cfg_bypass), .cfg_en(cfg_en),
        .tx_fifo_valid(tx_fifo_valid), .tx_fifo_data(tx_fifo_data),
        .tx_fifo_pop(tx_fifo_pop), .tx_underrun(tx_underrun),
        .rx_fifo_push(rx_fifo_push), .rx_fifo_data(rx_fifo_data),
        .line_rx_slots(line_rx_slots), .pcm_rx_slots(pcm_rx_slots),
        .line_tx_slots(line_tx_slots), .pcm_tx_slots(pcm_tx_slots)
    );

    task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_data();
        for (int i = 0; i < NF; i++) tx_fifo_data[i*8 +: 8] = 8'(8'hA0 + i*5 + seed);
        for (int s = 0; s < NS; s++) begin
            line_rx_slots[s*8 +: 8] = 8'(s*7 + seed);
            pcm_rx_slots[s*8 +: 8]  = 8'(s*13 + 8'h21 + seed*3);
        end
        seed++;
    endtask

    // all tasks start and end just after a falling edge
    task automatic cfg_write(bit dir, int fifo, int slot, bit byp, bit en);
        cfg_we = 1'b1; cfg_dir = dir; cfg_fifo = 5'(fifo);
        cfg_slot = 5'(slot); cfg_bypass = byp; cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
        if (fifo < NF) begin
            if (dir) prx[fifo] = '{en, byp, slot};
            else     ptx[fifo] = '{en, byp, slot};
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < NF; i++) begin
            cfg_write(1'b0, i, 0, 1'b0, 1'b0);
            cfg_write(1'b1, i, 0, 1'b0, 1'b0);
        end
    endtask

    function automatic bit usable(ent_t e);
        return e.en && e.slot != 0;
    endfunction

    task automatic run_frame(string tag, bit do_w = 0, bit wdir = 0, int wfifo = 0,
                             int wslot = 0, bit wbyp = 0, bit wen = 0);
        logic [NF-1:0] e_pop, e_und, e_push;
        logic [NF*8-1:0] e_rxd;
        logic [255:0] e_line, e_pcm;
        bit taken_tx[NS], taken_rx[NS];
        load_data();
        frame_tick = 1'b1;
        if (do_w) begin
            cfg_we = 1'b1; cfg_dir = wdir; cfg_fifo = 5'(wfifo);
            cfg_slot = 5'(wslot); cfg_bypass = wbyp; cfg_en = wen;
        end
        @(negedge clk);
        frame_tick = 1'b0;
        cfg_we = 1'b0;
        for (int i = 0; i < NF; i++) begin atx[i] = ptx[i]; arx[i] = prx[i]; end
        if (do_w && wfifo < NF) begin
            if (wdir) prx[wfifo] = '{wen, wbyp, wslot};
            else      ptx[wfifo] = '{wen, wbyp, wslot};
        end
        e_pop = '0; e_und = '0; e_push = '0; e_rxd = '0;
        e_line = '1; e_pcm = '1;
        for (int s = 0; s < NS; s++) begin taken_tx[s] = 0; taken_rx[s] = 0; end
        for (int i = 0; i < NF; i++) begin
            if (usable(atx[i]) && !taken_tx[atx[i].slot]) begin
                taken_tx[atx[i].slot] = 1;
                if (atx[i].byp)
                    e_line[atx[i].slot*8 +: 8] = pcm_rx_slots[atx[i].slot*8 +: 8];
                else if (tx_fifo_valid[i]) begin
                    e_line[atx[i].slot*8 +: 8] = tx_fifo_data[i*8 +: 8];
                    e_pop[i] = 1'b1;
                end else e_und[i] = 1'b1;
            end
            if (usable(arx[i]) && !taken_rx[arx[i].slot]) begin
                taken_rx[arx[i].slot] = 1;
                if (arx[i].byp)
                    e_pcm[arx[i].slot*8 +: 8] = line_rx_slots[arx[i].slot*8 +: 8];
                else begin
                    e_push[i] = 1'b1;
                    e_rxd[i*8 +: 8] = line_rx_slots[arx[i].slot*8 +: 8];
                end
            end
        end
        check({tag, " pop"}, 256'(tx_fifo_pop), 256'(e_pop));
        check({tag, " underrun"}, 256'(tx_underrun), 256'(e_und));
        check({tag, " push"}, 256'(rx_fifo_push), 256'(e_push));
        for (int i = 0; i < NF; i++)
            if (e_push[i]) check({tag, " rx byte"}, 256'(rx_fifo_data[i*8 +: 8]), 256'(e_rxd[i*8 +: 8]));
        @(negedge clk);
        check({tag, " line slots"}, line_tx_slots, e_line);
        check({tag, " pcm slots"}, pcm_tx_slots, e_pcm);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int slots[5] = '{1, 2, 13, 30, 31};
        logic [255:0] hold_line, hold_pcm;
        for (int i = 0; i < NF; i++) begin
            ptx[i] = '{0, 0, 0}; prx[i] = '{0, 0, 0};
        end
        repeat (3) @(negedge clk);
        // R1: reset state, while held and after release
        check("R1 line idle in reset", line_tx_slots, '1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 line idle", line_tx_slots, '1);
        check("R1 pcm idle", pcm_tx_slots, '1);
        check("R1 strobes", 256'({tx_fifo_pop, tx_underrun, rx_fifo_push}), '0);

        // R5 R7 R6: every FIFO against a spread of slots, full then empty
        for (int f = 0; f < NF; f++) begin
            for (int k = 0; k < 5; k++) begin
                clear_all();
                cfg_write(1'b0, f, slots[k], 1'b0, 1'b1);
                cfg_write(1'b1, f, slots[k], 1'b0, 1'b1);
                tx_fifo_valid = '1;
                run_frame("R5 R7 fifo route");
                tx_fifo_valid[f] = 1'b0;
                run_frame("R6 underrun");
                tx_fifo_valid = '1;
            end
        end

        // R8 R9: bypass entries through every FIFO number
        for (int f = 0; f < NF; f++) begin
            clear_all();
            cfg_write(1'b0, f, 4 + f*7, 1'b1, 1'b1);
            cfg_write(1'b1, f, 6 + f*6, 1'b1, 1'b1);
            run_frame("R8 R9 bypass");
        end

        // R10: disabled entries and slot 0 stay idle
        clear_all();
        cfg_write(1'b0, 0, 9, 1'b0, 1'b0);
        cfg_write(1'b1, 1, 9, 1'b0, 1'b0);
        cfg_write(1'b0, 2, 0, 1'b0, 1'b1);
        cfg_write(1'b1, 3, 0, 1'b1, 1'b1);
        run_frame("R10 unused");

        // R11: contention in both tables
        clear_all();
        cfg_write(1'b0, 3, 9, 1'b0, 1'b1);
        cfg_write(1'b0, 1, 9, 1'b0, 1'b1);
        cfg_write(1'b1, 2, 12, 1'b0, 1'b1);
        cfg_write(1'b1, 0, 12, 1'b1, 1'b1);
        run_frame("R11 priority");
        tx_fifo_valid[1] = 1'b0;
        run_frame("R11 priority empty winner");
        tx_fifo_valid = '1;

        // R3: writes to FIFO numbers that do not exist
        clear_all();
        cfg_write(1'b0, 4, 7, 1'b0, 1'b1);
        cfg_write(1'b1, 31, 7, 1'b0, 1'b1);
        cfg_write(1'b0, 20, 8, 1'b1, 1'b1);
        run_frame("R3 out of range");

        // R2: a write in the tick cycle waits for the following tick
        clear_all();
        cfg_write(1'b0, 0, 3, 1'b0, 1'b1);
        run_frame("R2 before");
        run_frame("R2 same cycle", 1'b1, 1'b0, 0, 20, 1'b0, 1'b1);
        run_frame("R2 next frame");

        // R4: nothing moves between ticks
        hold_line = line_tx_slots;
        hold_pcm = pcm_tx_slots;
        load_data();
        cfg_write(1'b0, 1, 5, 1'b0, 1'b1);
        repeat (4) begin
            @(negedge clk);
            check("R4 idle strobes", 256'({tx_fifo_pop, tx_underrun, rx_fifo_push}), '0);
        end
        check("R4 line hold", line_tx_slots, hold_line);
        check("R4 pcm hold", pcm_tx_slots, hold_pcm);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule